// File: doc/BRIEF.md
# Audio Clock Regeneration Counter

This block supplies the two numbers a display link transmitter puts in its audio clock regeneration packet: the divider N and the cycle time stamp CTS. It also tells the packet scheduler, by a one-cycle request strobe in the pixel domain, each time a fresh CTS value is ready to go out. The sample rate is fixed at elaboration time, and N follows from it by sample-rate family. Rates that divide by 125 (32, 48, 96, 192 kHz) use one formula. Rates that divide by 225 (44.1, 88.2, 176.4 kHz) use another.

CTS is measured rather than looked up. The audio clock runs at the sample rate. In the audio domain, a counter marks off windows of N/128 audio clocks and flips a toggle at the end of each window. The toggle crosses into the pixel domain through a two-flop synchronizer and an edge detector. A free-running pixel-clock counter is captured and restarted on each detected window boundary, so CTS equals the number of pixel clocks in one audio window. Packet assembly, error-correction coding and serialization sit downstream and are not part of this block.

Top module: `acr_counter`

## Requirements
- R1: For a sample rate that divides by 125, `n_value` equals 16 × rate / 125 (48000 gives 6144, 32000 gives 4096).
- R2: For a sample rate that divides by 225 and not by 125, `n_value` equals 32 × rate / 225 (44100 gives 6272).
- R3: In steady state, `cts_value` equals the number of pixel clocks that elapse during N/128 audio clocks, which is (N/128) × k when the audio period is exactly k pixel periods.
- R4: `send_req` is high for exactly one pixel clock per captured CTS value. Successive requests are spaced by the length of one audio window in pixel clocks.
- R5: `cts_value` changes only in a cycle where `send_req` is high. It is held unchanged at all other times.
- R6: While reset is applied, `cts_value` is 0 and `send_req` is 0. After reset, no request is issued until a complete window has been measured. The first request therefore comes more than one window after reset, and it already carries the full-window count.
- R7: When the ratio between the audio and pixel clocks changes, `cts_value` settles to the new window length within two windows and then stays there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_aud | input | 1 | Audio clock, running at the sample rate |
| rst_aud | input | 1 | Synchronous active-high reset, audio domain |
| clk_pix | input | 1 | Pixel clock |
| rst_pix | input | 1 | Synchronous active-high reset, pixel domain |
| n_value | output | 20 | Divider N for the regeneration packet |
| cts_value | output | 20 | Most recent measured cycle time stamp |
| send_req | output | 1 | One-cycle request to schedule a regeneration packet |

## Verification
A wrong audio window length or a slipped toggle shows at the ports as a `cts_value` off by a multiple of the clock ratio. It also shows as request spacing that no longer matches (N/128) × k, and either symptom appears at the second request after the fault. A pixel counter that is not restarted, or a capture taken one cycle off, shifts every CTS by a constant, and this is visible at the first request. The bench sweeps integer clock ratios from 3 to 9 on two sample-rate families. It predicts each count arithmetically, and it checks the first request after reset against the full-window value.

// File: rtl/acr_pkg.sv
package acr_pkg;

  localparam int unsigned ACR_VAL_W = 20;

  typedef logic [ACR_VAL_W-1:0] acr_val_t;

  function automatic acr_val_t acr_n_for_rate(input int unsigned rate);
    if (rate % 125 == 0)
      return acr_val_t'((16 * rate) / 125);
    else if (rate % 225 == 0)
      return acr_val_t'((32 * rate) / 225);
    else
      return acr_val_t'((16 * rate) / 125);
  endfunction

endpackage

// File: rtl/acr_aud_window.sv
module acr_aud_window #(
  parameter int unsigned WIN_LEN = 48
) (
  input  logic clk_aud,
  input  logic rst_aud,
  output logic win_tog
);

  localparam int unsigned CNT_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tog_q;

  always_ff @(posedge clk_aud) begin
    if (rst_aud) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      tog_q <= ~tog_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign win_tog = tog_q;

  assert_cnt_range_R3: assert property (@(posedge clk_aud) disable iff (rst_aud)
    cnt_q <= LAST);

  assert_tog_on_wrap_R3: assert property (@(posedge clk_aud) disable iff (rst_aud)
    (cnt_q == LAST) |=> (tog_q != $past(tog_q)));

  assert_tog_hold_R3: assert property (@(posedge clk_aud) disable iff (rst_aud)
    (cnt_q != LAST) |=> $stable(tog_q));

endmodule

// File: rtl/acr_tog_sync.sv
module acr_tog_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_pix,
  input  logic rst_pix,
  input  logic tog_in,
  output logic edge_ev
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk_pix) begin
    if (rst_pix) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], tog_in};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign edge_ev = chain_q[STAGES-1] ^ last_q;

  assert_single_event_R4: assert property (@(posedge clk_pix) disable iff (rst_pix)
    edge_ev |=> !edge_ev);

endmodule

// File: rtl/acr_cts_meter.sv
module acr_cts_meter
  import acr_pkg::*;
(
  input  logic     clk_pix,
  input  logic     rst_pix,
  input  logic     edge_ev,
  output acr_val_t cts,
  output logic     req
);

  localparam acr_val_t SAT = '1;

  acr_val_t pcnt_q;
  acr_val_t cts_q;
  logic     req_q;
  logic     primed_q;

  always_ff @(posedge clk_pix) begin
    if (rst_pix) begin
      pcnt_q   <= '0;
      cts_q    <= '0;
      req_q    <= 1'b0;
      primed_q <= 1'b0;
    end else if (edge_ev) begin
      pcnt_q   <= acr_val_t'(1);
      primed_q <= 1'b1;
      if (primed_q) begin
        cts_q <= pcnt_q;
        req_q <= 1'b1;
      end else begin
        req_q <= 1'b0;
      end
    end else begin
      req_q <= 1'b0;
      if (pcnt_q != SAT)
        pcnt_q <= pcnt_q + 1'b1;
    end
  end

  assign cts = cts_q;
  assign req = req_q;

  assert_req_pulse_R4: assert property (@(posedge clk_pix) disable iff (rst_pix)
    req_q |=> !req_q);

  assert_cts_hold_R5: assert property (@(posedge clk_pix) disable iff (rst_pix)
    !req_q |-> $stable(cts_q));

  assert_no_early_req_R6: assert property (@(posedge clk_pix) disable iff (rst_pix)
    !primed_q |-> !req_q);

endmodule

// File: rtl/acr_counter.sv
module acr_counter
  import acr_pkg::*;
#(
  parameter int unsigned SAMPLE_RATE = 48000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_aud,
  input  logic        rst_aud,
  input  logic        clk_pix,
  input  logic        rst_pix,
  output logic [19:0] n_value,
  output logic [19:0] cts_value,
  output logic        send_req
);

  localparam acr_val_t    N_VAL   = acr_n_for_rate(SAMPLE_RATE);
  localparam int unsigned WIN_LEN = int'(N_VAL) / 128;

  logic     win_tog;
  logic     edge_ev;
  acr_val_t cts_w;
  logic     req_w;
  acr_val_t n_q;

  acr_aud_window #(.WIN_LEN(WIN_LEN)) u_window (
    .clk_aud (clk_aud),
    .rst_aud (rst_aud),
    .win_tog (win_tog)
  );

  acr_tog_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_pix (clk_pix),
    .rst_pix (rst_pix),
    .tog_in  (win_tog),
    .edge_ev (edge_ev)
  );

  acr_cts_meter u_meter (
    .clk_pix (clk_pix),
    .rst_pix (rst_pix),
    .edge_ev (edge_ev),
    .cts     (cts_w),
    .req     (req_w)
  );

  always_ff @(posedge clk_pix) begin
    n_q <= N_VAL;
  end

  assign n_value   = n_q;
  assign cts_value = cts_w;
  assign send_req  = req_w;

  assert_reset_quiet_R6: assert property (@(posedge clk_pix)
    rst_pix |=> (!send_req && cts_value == '0));

endmodule

// File: tb/acr_counter_tb.sv
`timescale 1ns/1ps
module acr_counter_tb;

  logic clk_pix = 1'b0;
  logic clk_aud = 1'b0;
  logic rst_pix = 1'b1;
  logic rst_aud = 1'b1;
  int   k = 5;

  logic [19:0] n_a, cts_a, n_b, cts_b, n_c, cts_c;
  logic        req_a, req_b, req_c;

  int checks = 0;
  int failures = 0;
  bit timed_out = 0;

  always #2 clk_pix = ~clk_pix;

  initial begin
    #1;
    forever #(2 * k) clk_aud = ~clk_aud;
  end

  acr_counter #(.SAMPLE_RATE(48000)) u_dut (
    .clk_aud(clk_aud), .rst_aud(rst_aud), .clk_pix(clk_pix), .rst_pix(rst_pix),
    .n_value(n_a), .cts_value(cts_a), .send_req(req_a));

  acr_counter #(.SAMPLE_RATE(44100)) u_dut_b (
    .clk_aud(clk_aud), .rst_aud(rst_aud), .clk_pix(clk_pix), .rst_pix(rst_pix),
    .n_value(n_b), .cts_value(cts_b), .send_req(req_b));

  acr_counter #(.SAMPLE_RATE(32000)) u_dut_c (
    .clk_aud(clk_aud), .rst_aud(rst_aud), .clk_pix(clk_pix), .rst_pix(rst_pix),
    .n_value(n_c), .cts_value(cts_c), .send_req(req_c));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_req_a(output int cyc);
    logic [19:0] prev;
    bit moved;
    cyc = 0; prev = cts_a; moved = 0;
    do begin
      @(negedge clk_pix);
      cyc++;
      if (!req_a && cts_a != prev) moved = 1;
    end while (!req_a && cyc < 20000);
    if (cyc >= 20000) timed_out = 1;
    check(!moved, "R5 cts_a moved without request", moved, 0);
  endtask

  task automatic wait_req_b(output int cyc);
    logic [19:0] prev;
    bit moved;
    cyc = 0; prev = cts_b; moved = 0;
    do begin
      @(negedge clk_pix);
      cyc++;
      if (!req_b && cts_b != prev) moved = 1;
    end while (!req_b && cyc < 20000);
    if (cyc >= 20000) timed_out = 1;
    check(!moved, "R5 cts_b moved without request", moved, 0);
  endtask

  initial begin
    #600000;
    check(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc;
    repeat (40) @(negedge clk_pix);
    // R6: quiet while reset is applied
    check(req_a == 0, "R6 req during reset", req_a, 0);
    check(cts_a == 0, "R6 cts during reset", cts_a, 0);
    check(req_b == 0, "R6 req_b during reset", req_b, 0);
    // R1 / R2: N by family
    check(n_a == 6144, "R1 N at 48000", n_a, 6144);
    check(n_c == 4096, "R1 N at 32000", n_c, 4096);
    check(n_b == 6272, "R2 N at 44100", n_b, 6272);
    rst_pix = 0; rst_aud = 0;
    // R6: first request only after a full window, carrying full count
    wait_req_a(cyc);
    check(cyc > 48 * 5, "R6 first request too early", cyc, 48 * 5 + 1);
    check(cyc <= 2 * 48 * 5 + 8, "R6 first request too late", cyc, 2 * 48 * 5);
    check(cts_a == 48 * 5, "R6 first cts full window", cts_a, 48 * 5);
    @(negedge clk_pix);
    check(req_a == 0, "R4 pulse width", req_a, 0);

    // R3 / R4 / R7: sweep of clock ratios
    for (int r = 3; r <= 9; r++) begin
      k = r;
      wait_req_a(cyc);
      wait_req_a(cyc);
      for (int i = 0; i < 3; i++) begin
        wait_req_a(cyc);
        check(cts_a == 48 * r, "R3 R7 cts at 48000", cts_a, 48 * r);
        if (i > 0) check(cyc + 1 == 48 * r, "R4 request spacing", cyc + 1, 48 * r);
        @(negedge clk_pix);
        check(req_a == 0, "R4 single-cycle request", req_a, 0);
      end
      wait_req_b(cyc);
      for (int i = 0; i < 2; i++) begin
        wait_req_b(cyc);
        check(cts_b == 49 * r, "R3 R7 cts at 44100", cts_b, 49 * r);
        check(cyc == 49 * r, "R4 request spacing b", cyc, 49 * r);
      end
    end

    check(!timed_out, "request timeout", timed_out, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule